// File: doc/BRIEF.md
# Addressed Serial Receiver with ID Filtering

This block receives asynchronous serial frames on a single line and hands each byte to software through a small register-style interface. A frame has one low start bit, eight data bits sent least significant bit first, one address-marker bit and one high stop bit. When the marker bit is 1 the frame carries a station ID. When it is 0 the frame carries ordinary data. The line is sampled at sixteen times the bit rate, using a one-cycle enable pulse from an external baud generator. Each bit is taken at the middle of its bit time.

Software turns on ID filtering by writing the filter enable to 1. While the filter is on, data frames are thrown away without a trace. The first well-formed ID frame is delivered, and the hardware then switches the filter off by itself. Software compares the ID with its own. If the ID is foreign, it writes the filter enable back to 1. If the ID matches, it reads the data frames that follow. An overrun or a framing error blocks all further reception until software clears the error. The synchronised line level can be read back, so that a break can be recognised after a framing error.

Top module: `mpuart_rx`

## Requirements
- R1: After reset the outputs are rdf=0, ovr_err=0, frm_err=0, mp_en=0, id_flag=0, rx_data=0 and rxd_level=1.
- R2: With mp_en=0, a well-formed frame sets rdf and loads rx_data. The eight data bits follow the start bit with the least significant bit first, the marker bit follows the data bits, and the stop bit comes last.
- R3: Writing mp_wr with mp_wdata sets mp_en. While mp_en=1, a frame whose marker bit is 0 changes none of rdf, ovr_err, frm_err, rx_data or id_flag.
- R4: While mp_en=1, a well-formed frame whose marker bit is 1 sets rdf, loads rx_data, and clears mp_en in the same cycle.
- R5: A well-formed frame that completes while rdf=1 sets ovr_err and leaves rx_data at its old value.
- R6: A frame whose stop bit is sampled as 0 sets frm_err and loads rx_data, but leaves rdf unchanged.
- R7: While ovr_err or frm_err is 1, completed frames change none of the flags and leave rx_data unchanged.
- R8: A one-cycle pulse on rdf_clr, ovr_clr or frm_clr clears the matching flag on the next clock edge. If a receive event sets the same flag in that cycle, the event wins.
- R9: A start bit that is back to high at its midpoint is discarded, and no frame is received from it.
- R10: rxd_level follows rxd with a delay of two clock cycles.
- R11: id_flag holds the marker bit of the last frame that set rdf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick16 | input | 1 | Oversampling enable, sixteen pulses per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| mp_wr | input | 1 | Write strobe for the filter enable |
| mp_wdata | input | 1 | Value written to the filter enable |
| rdf_clr | input | 1 | Clear strobe for rdf |
| ovr_clr | input | 1 | Clear strobe for ovr_err |
| frm_clr | input | 1 | Clear strobe for frm_err |
| mp_en | output | 1 | ID filter enable (ID-wait active) |
| rx_data | output | 8 | Received byte |
| rdf | output | 1 | Receive data full |
| id_flag | output | 1 | Marker bit of the last delivered frame |
| ovr_err | output | 1 | Overrun error |
| frm_err | output | 1 | Framing error |
| rxd_level | output | 1 | Synchronised level of the receive line |

## Verification
Each frame result is ready a few clock cycles after the middle of the stop bit. The delay is the two-stage line synchroniser, then the framer's output register, then the status register. The bench therefore holds the line idle for one further bit time (64 clocks) after the stop bit and only then compares every output with its model. A clear or a filter-enable write takes effect on the next clock edge, so the bench samples it on the following falling edge. The line level readback is sampled three clock cycles after a change of rxd, which covers its two-cycle delay.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_START  = 2'd1,
    ST_BITS   = 2'd2,
    ST_WAITHI = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mpuart_framer.sv
module mpuart_framer
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] dat,
  output logic              mpb,
  output logic              stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int NB = DATA_W + 2;
  localparam int BW = $clog2(NB);
  localparam logic [CW-1:0] MID   = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL  = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTB = BW'(NB - 1);

  rx_state_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bidx_q, bidx_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              mpb_q, mpb_d;
  logic              stop_q, stop_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bidx_d = bidx_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    dat_d  = dat_q;
    mpb_d  = mpb_q;
    stop_d = stop_q;
    if (tick) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rxd) begin
            st_d  = ST_START;
            cnt_d = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID) begin
            cnt_d  = '0;
            bidx_d = '0;
            st_d   = rxd ? ST_IDLE : ST_BITS;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_BITS: begin
          if (cnt_q == FULL) begin
            cnt_d = '0;
            if (bidx_q == LASTB) begin
              done_d = 1'b1;
              dat_d  = sh_q[DATA_W-1:0];
              mpb_d  = sh_q[DATA_W];
              stop_d = rxd;
              st_d   = rxd ? ST_IDLE : ST_WAITHI;
            end else begin
              sh_d   = {rxd, sh_q[DATA_W:1]};
              bidx_d = bidx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WAITHI: begin
          if (rxd) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      dat_q  <= '0;
      mpb_q  <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bidx_q <= bidx_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      dat_q  <= dat_d;
      mpb_q  <= mpb_d;
      stop_q <= stop_d;
    end
  end

  assign done    = done_q;
  assign dat     = dat_q;
  assign mpb     = mpb_q;
  assign stop_ok = stop_q;

  // R2: one completion pulse per frame
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: a start bit seen high at its midpoint returns the framer to idle
  p_glitch_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick && cnt_q == MID && rxd) |=> (st_q == ST_IDLE && !done_q));
endmodule

// File: rtl/mpuart_regs.sv
module mpuart_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] dat,
  input  logic              mpb,
  input  logic              stop_ok,
  input  logic              mp_wr,
  input  logic              mp_wdata,
  input  logic              rdf_clr,
  input  logic              ovr_clr,
  input  logic              frm_clr,
  output logic              mp_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdf,
  output logic              id_flag,
  output logic              ovr_err,
  output logic              frm_err
);
  logic              mp_q, mp_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              rdf_q, rdf_d;
  logic              id_q, id_d;
  logic              ovr_q, ovr_d;
  logic              frm_q, frm_d;
  logic              locked, dropped, take;
  logic              set_frm, set_ovr, set_rdf;

  always_comb begin
    locked  = ovr_q | frm_q;
    dropped = mp_q & ~mpb;
    take    = done & ~locked & ~dropped;
    set_frm = take & ~stop_ok;
    set_ovr = take & stop_ok & rdf_q;
    set_rdf = take & stop_ok & ~rdf_q;

    mp_d   = mp_q;
    data_d = data_q;
    rdf_d  = rdf_q;
    id_d   = id_q;
    ovr_d  = ovr_q;
    frm_d  = frm_q;

    if (mp_wr)        mp_d  = mp_wdata;
    if (rdf_clr)      rdf_d = 1'b0;
    if (ovr_clr)      ovr_d = 1'b0;
    if (frm_clr)      frm_d = 1'b0;

    if (set_frm) begin
      frm_d  = 1'b1;
      data_d = dat;
    end
    if (set_ovr) ovr_d = 1'b1;
    if (set_rdf) begin
      rdf_d  = 1'b1;
      data_d = dat;
      id_d   = mpb;
      if (mp_q) mp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp_q   <= 1'b0;
      data_q <= '0;
      rdf_q  <= 1'b0;
      id_q   <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      mp_q   <= mp_d;
      data_q <= data_d;
      rdf_q  <= rdf_d;
      id_q   <= id_d;
      ovr_q  <= ovr_d;
      frm_q  <= frm_d;
    end
  end

  assign mp_en   = mp_q;
  assign rx_data = data_q;
  assign rdf     = rdf_q;
  assign id_flag = id_q;
  assign ovr_err = ovr_q;
  assign frm_err = frm_q;

  // R3: filtered data frames leave the data register alone
  p_drop_keeps_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_q && !mpb) |=> $stable(data_q));

  // R4: an accepted ID frame ends ID-wait and fills the data register
  p_id_ends_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mp_q && mpb && stop_ok && !rdf_q && !ovr_q && !frm_q) |=> (!mp_q && rdf_q && id_q));

  // R5: overrun keeps the old byte
  p_overrun_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovr_q && !frm_q && !(mp_q && !mpb) && stop_ok && rdf_q) |=> (ovr_q && $stable(data_q)));

  // R6: bad stop bit raises the framing flag
  p_frame_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovr_q && !frm_q && !(mp_q && !mpb) && !stop_ok) |=> frm_q);

  // R7: pending error blocks reception
  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ovr_q || frm_q)) |=> $stable(data_q));
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              mp_wr,
  input  logic              mp_wdata,
  input  logic              rdf_clr,
  input  logic              ovr_clr,
  input  logic              frm_clr,
  output logic              mp_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdf,
  output logic              id_flag,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              rxd_level
);
  logic              rst_int_n;
  logic              rxd_s;
  logic              f_done;
  logic [DATA_W-1:0] f_dat;
  logic              f_mpb;
  logic              f_stop;

  mpuart_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  mpuart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_int_n), .d(rxd), .q(rxd_s)
  );

  mpuart_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_int_n), .tick(tick16), .rxd(rxd_s),
    .done(f_done), .dat(f_dat), .mpb(f_mpb), .stop_ok(f_stop)
  );

  mpuart_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .done(f_done), .dat(f_dat), .mpb(f_mpb), .stop_ok(f_stop),
    .mp_wr(mp_wr), .mp_wdata(mp_wdata),
    .rdf_clr(rdf_clr), .ovr_clr(ovr_clr), .frm_clr(frm_clr),
    .mp_en(mp_en), .rx_data(rx_data), .rdf(rdf), .id_flag(id_flag),
    .ovr_err(ovr_err), .frm_err(frm_err)
  );

  assign rxd_level = rxd_s;
endmodule

// File: tb/mpuart_rx_tb.sv
module mpuart_rx_tb;
  localparam int BITCLK = 64;

  logic       clk, rst_n, tick16, rxd;
  logic       mp_wr, mp_wdata, rdf_clr, ovr_clr, frm_clr;
  logic       mp_en, rdf, id_flag, ovr_err, frm_err, rxd_level;
  logic [7:0] rx_data;

  int  n_chk, n_err;
  bit  e_mp, e_rdf, e_id, e_ovr, e_frm;
  logic [7:0] e_data;
  logic [1:0] tdiv;

  mpuart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .mp_wr(mp_wr), .mp_wdata(mp_wdata),
    .rdf_clr(rdf_clr), .ovr_clr(ovr_clr), .frm_clr(frm_clr),
    .mp_en(mp_en), .rx_data(rx_data), .rdf(rdf), .id_flag(id_flag),
    .ovr_err(ovr_err), .frm_err(frm_err), .rxd_level(rxd_level)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdiv   <= 2'd0;
      tick16 <= 1'b0;
    end else begin
      tdiv   <= tdiv + 2'd1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "rdf", int'(rdf), int'(e_rdf));
    chk(req, "rx_data", int'(rx_data), int'(e_data));
    chk(req, "ovr_err", int'(ovr_err), int'(e_ovr));
    chk(req, "frm_err", int'(frm_err), int'(e_frm));
    chk(req, "mp_en", int'(mp_en), int'(e_mp));
    chk(req, "id_flag", int'(id_flag), int'(e_id));
  endtask

  function automatic void model_frame(input logic [7:0] d, input bit mp, input bit stp);
    if (e_ovr || e_frm) return;
    if (e_mp && !mp) return;
    if (!stp) begin
      e_frm  = 1'b1;
      e_data = d;
    end else if (e_rdf) begin
      e_ovr = 1'b1;
    end else begin
      e_rdf  = 1'b1;
      e_data = d;
      e_id   = mp;
      if (e_mp && mp) e_mp = 1'b0;
    end
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit mp, input bit stp);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = mp;
    repeat (BITCLK) @(negedge clk);
    rxd = stp;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
    model_frame(d, mp, stp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rdf_clr = 1'b1;
      1: ovr_clr = 1'b1;
      2: frm_clr = 1'b1;
      default: begin mp_wr = 1'b1; mp_wdata = 1'b1; end
    endcase
    @(negedge clk);
    rdf_clr = 1'b0; ovr_clr = 1'b0; frm_clr = 1'b0; mp_wr = 1'b0; mp_wdata = 1'b0;
    case (which)
      0: e_rdf = 1'b0;
      1: e_ovr = 1'b0;
      2: e_frm = 1'b0;
      default: e_mp = 1'b1;
    endcase
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [7:0] rd;
    bit rmp, rstp;
    n_chk = 0; n_err = 0;
    seed = 32'd1234;
    rd = $urandom(seed);
    rst_n = 1'b0; rxd = 1'b1;
    mp_wr = 1'b0; mp_wdata = 1'b0; rdf_clr = 1'b0; ovr_clr = 1'b0; frm_clr = 1'b0;
    e_mp = 0; e_rdf = 0; e_id = 0; e_ovr = 0; e_frm = 0; e_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_all("R1");
    chk("R1", "rxd_level", int'(rxd_level), 1);

    // R10 and R9: short low pulse on the line
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "rxd_level low", int'(rxd_level), 0);
    repeat (9) @(negedge clk);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "rxd_level high", int'(rxd_level), 1);
    repeat (2 * BITCLK) @(negedge clk);
    chk_all("R9");

    // R2 and R11: data frame with filter off
    send_frame(8'hA5, 1'b0, 1'b1);
    chk_all("R2");
    chk("R11", "id_flag", int'(id_flag), 0);

    // R5: overrun keeps old byte
    send_frame(8'h3C, 1'b0, 1'b1);
    chk_all("R5");
    chk("R5", "ovr_err", int'(ovr_err), 1);

    // R7: lockout by overrun
    send_frame(8'h11, 1'b1, 1'b1);
    chk_all("R7");

    // R8: clear strobes
    pulse(1);
    pulse(0);
    chk_all("R8");

    // R3: filter on, data frame dropped
    pulse(3);
    chk("R3", "mp_en", int'(mp_en), 1);
    send_frame(8'h77, 1'b0, 1'b1);
    chk_all("R3");

    // R4 and R11: ID frame ends the wait
    send_frame(8'h42, 1'b1, 1'b1);
    chk_all("R4");
    chk("R4", "mp_en cleared", int'(mp_en), 0);
    chk("R11", "id_flag", int'(id_flag), 1);

    // R2: following data frame delivered
    pulse(0);
    send_frame(8'h99, 1'b0, 1'b1);
    chk_all("R2");

    // R6: framing error loads byte, rdf unchanged
    pulse(0);
    send_frame(8'h5A, 1'b0, 1'b0);
    chk_all("R6");
    chk("R6", "frm_err", int'(frm_err), 1);

    // R7: lockout by framing error
    send_frame(8'h12, 1'b0, 1'b1);
    chk_all("R7");
    pulse(2);
    chk_all("R8");

    // random mix
    for (int k = 0; k < 30; k++) begin
      rd   = $urandom();
      rmp  = $urandom() % 2;
      rstp = ($urandom() % 8) != 0;
      send_frame(rd, rmp, rstp);
      chk_all("R2");
      if ($urandom() % 2) pulse(0);
      if (e_ovr && ($urandom() % 2)) pulse(1);
      if (e_frm && ($urandom() % 2)) pulse(2);
      if (($urandom() % 4) == 0) pulse(3);
      chk_all("R8");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule